// File: doc/BRIEF.md
# Return Address Stack with Banked Condition Flags

This block keeps the return addresses of a small processor core in a six-entry last-in-first-out store that software cannot address. Calls, interrupt entries and non-maskable-interrupt entries save the current program counter. Returns and interrupt returns take it back. The store saturates at both ends. When more than six addresses are saved, the oldest ones are dropped. When an address is taken from an empty store, the store stays empty and the next sequential address is returned.

The block also holds three carry/zero flag pairs, one for each execution context: normal, interrupt and non-maskable. Only the pair of the active context is visible to the ALU and written by it. A short context history remembers where each interrupt entry came from. An interrupt return can therefore resume the interrupted context and its flags, including a non-maskable interrupt that was nested inside an ordinary one. Instruction decode, the ALU and vector fetch sit outside this block.

Top module: `ret_stack_ctx`

## Requirements
- R1: After reset the stack is empty, the active context is non-maskable (ctxOut = 2'b10), and all six flag bits read 0.
- R2: A call saves pcIn. Each pop returns the saved addresses newest first on popPc, with popEmpty low.
- R3: After more than six saves without pops, only the six newest addresses are returned, newest first. Any further pop then finds the stack empty.
- R4: A pop on an empty stack asserts popEmpty and drives popPc = pcIn + 1 (modulo 4096) in that same cycle. The stack stays empty.
- R5: An interrupt entry saves pcIn and makes the interrupt context active (ctxOut = 2'b01).
- R6: A non-maskable entry saves pcIn and makes the non-maskable context active (ctxOut = 2'b10).
- R7: An interrupt return pops like a return and restores the context that was active before the latest entry still recorded. This includes the interrupt context after a non-maskable entry that was nested inside an interrupt.
- R8: A plain return never changes ctxOut.
- R9: carryOut and zeroOut show the pair of the active context. A flag write updates only that pair. Pairs keep their values across context switches.
- R10: When several requests arrive in one cycle, exactly one is acted on, in the order non-maskable entry, interrupt entry, call, interrupt return, return.
- R11: An interrupt return with no recorded history restores the normal context (ctxOut = 2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pcIn | input | 12 | Current program counter, saved on entries and calls |
| callReq | input | 1 | Subroutine call: save pcIn |
| intReq | input | 1 | Interrupt entry: save pcIn, switch to the interrupt context |
| nmiReq | input | 1 | Non-maskable entry: save pcIn, switch to the non-maskable context |
| retReq | input | 1 | Return: pop an address |
| retiReq | input | 1 | Interrupt return: pop an address and restore the previous context |
| flagWr | input | 1 | Write carryIn and zeroIn into the active pair |
| carryIn | input | 1 | New carry value |
| zeroIn | input | 1 | New zero value |
| popPc | output | 12 | Popped address, valid in the cycle of a pop |
| popEmpty | output | 1 | Pop found the stack empty; popPc is pcIn + 1 |
| carryOut | output | 1 | Carry of the active pair |
| zeroOut | output | 1 | Zero of the active pair |
| ctxOut | output | 2 | Active context: 00 normal, 01 interrupt, 10 non-maskable |

## Verification
A wrong level shift or a wrong depth count shows at the first pop that reaches the damaged entry. The damage appears as a wrong popPc, or as popEmpty in the wrong cycle. For this reason the scoreboard compares every pop, including deep and saturated sequences. A corrupted context history stays hidden until the matching interrupt return. A wrong flag-bank selection shows on carryOut or zeroOut in the cycle after the switch. Nested interrupt entries are therefore unwound, and the flags are checked after each switch.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    CTX_NORMAL = 2'b00,
    CTX_INT    = 2'b01,
    CTX_NMI    = 2'b10
  } ctx_e;

  localparam int NUM_CTX = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic popShift;
    logic popUnder;
  } strobe_t;
endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int HIST  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    callReq,
  input  logic    intReq,
  input  logic    nmiReq,
  input  logic    retReq,
  input  logic    retiReq,
  output strobe_t strb,
  output ctx_e    ctxQ
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] depthQ;
  ctx_e          histQ [HIST];
  logic          anyPush, retiWin, retWin, anyPop, isEmpty;
  logic          enterCtx;
  ctx_e          enterTarget;

  // request priority: nmi, int, call, reti, ret
  always_comb begin
    anyPush     = nmiReq | intReq | callReq;
    retiWin     = !anyPush && retiReq;
    retWin      = !anyPush && !retiReq && retReq;
    anyPop      = retiWin | retWin;
    isEmpty     = (depthQ == '0);
    enterCtx    = nmiReq | intReq;
    enterTarget = nmiReq ? CTX_NMI : CTX_INT;
    strb.push     = anyPush;
    strb.popShift = anyPop && !isEmpty;
    strb.popUnder = anyPop && isEmpty;
  end

  // saturating depth counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ <= '0;
    end else if (strb.push) begin
      if (depthQ != CW'(DEPTH)) depthQ <= depthQ + 1'b1;
    end else if (strb.popShift) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  // active context
  always_ff @(posedge clk) begin
    if (!rstN)          ctxQ <= CTX_NMI;
    else if (enterCtx)  ctxQ <= enterTarget;
    else if (retiWin)   ctxQ <= histQ[0];
  end

  // context history: shifts deeper on entry, up on interrupt return
  always_ff @(posedge clk) begin
    if (!rstN)         histQ[0] <= CTX_NORMAL;
    else if (enterCtx) histQ[0] <= ctxQ;
    else if (retiWin)  histQ[0] <= (HIST > 1) ? histQ[HIST > 1 ? 1 : 0] : CTX_NORMAL;
  end

  for (genvar h = 1; h < HIST; h++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN)         histQ[h] <= CTX_NORMAL;
      else if (enterCtx) histQ[h] <= histQ[h-1];
      else if (retiWin)  histQ[h] <= (h == HIST - 1) ? CTX_NORMAL : histQ[(h == HIST - 1) ? h : h + 1];
    end
  end

  assert_depth_max_R3: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= CW'(DEPTH));
  assert_nmi_enter_R6: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> ctxQ == CTX_NMI);
  assert_int_enter_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !nmiReq) |=> ctxQ == CTX_INT);
  assert_ret_keeps_ctx_R8: assert property (@(posedge clk) disable iff (!rstN)
    retWin |=> $stable(ctxQ));
  assert_single_action_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.popShift, strb.popUnder}));
endmodule

// File: rtl/rsc_dpath.sv
module rsc_dpath
  import rsc_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  ctx_e             ctx,
  input  logic [WIDTH-1:0] pcIn,
  input  logic             flagWr,
  input  logic             carryIn,
  input  logic             zeroIn,
  output logic [WIDTH-1:0] popPc,
  output logic             carryOut,
  output logic             zeroOut
);
  logic [WIDTH-1:0] lvlQ [DEPTH];
  logic             carryQ [NUM_CTX];
  logic             zeroQ  [NUM_CTX];

  // level 0 takes the pc on push, level 1 contents on pop
  always_ff @(posedge clk) begin
    if (!rstN)              lvlQ[0] <= '0;
    else if (strb.push)     lvlQ[0] <= pcIn;
    else if (strb.popShift) lvlQ[0] <= (DEPTH > 1) ? lvlQ[DEPTH > 1 ? 1 : 0] : '0;
  end

  for (genvar l = 1; l < DEPTH; l++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rstN)              lvlQ[l] <= '0;
      else if (strb.push)     lvlQ[l] <= lvlQ[l-1];
      else if (strb.popShift) lvlQ[l] <= (l == DEPTH - 1) ? '0 : lvlQ[(l == DEPTH - 1) ? l : l + 1];
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        carryQ[c] <= 1'b0;
        zeroQ[c]  <= 1'b0;
      end else if (flagWr && ctx == ctx_e'(c)) begin
        carryQ[c] <= carryIn;
        zeroQ[c]  <= zeroIn;
      end
    end
  end

  always_comb begin
    popPc    = strb.popUnder ? pcIn + 1'b1 : lvlQ[0];
    carryOut = 1'b0;
    zeroOut  = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (ctx == ctx_e'(c)) begin
        carryOut = carryQ[c];
        zeroOut  = zeroQ[c];
      end
    end
  end

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> lvlQ[0] == $past(pcIn));
  assert_pop_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.popShift |=> lvlQ[0] == $past(lvlQ[DEPTH > 1 ? 1 : 0]));
  assert_under_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.popUnder |=> $stable(lvlQ[0]));
  assert_normal_bank_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagWr && ctx != CTX_NORMAL) |=> (carryQ[0] == $past(carryQ[0]) && zeroQ[0] == $past(zeroQ[0])));
endmodule

// File: rtl/ret_stack_ctx.sv
module ret_stack_ctx
  import rsc_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 12,
  parameter int HIST  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pcIn,
  input  logic             callReq,
  input  logic             intReq,
  input  logic             nmiReq,
  input  logic             retReq,
  input  logic             retiReq,
  input  logic             flagWr,
  input  logic             carryIn,
  input  logic             zeroIn,
  output logic [WIDTH-1:0] popPc,
  output logic             popEmpty,
  output logic             carryOut,
  output logic             zeroOut,
  output logic [1:0]       ctxOut
);
  strobe_t strb;
  ctx_e    ctxQ;

  rsc_ctrl #(.DEPTH(DEPTH), .HIST(HIST)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .callReq(callReq), .intReq(intReq), .nmiReq(nmiReq),
    .retReq(retReq), .retiReq(retiReq),
    .strb(strb), .ctxQ(ctxQ)
  );

  rsc_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ctx(ctxQ), .pcIn(pcIn),
    .flagWr(flagWr), .carryIn(carryIn), .zeroIn(zeroIn),
    .popPc(popPc), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  assign popEmpty = strb.popUnder;
  assign ctxOut   = ctxQ;
endmodule

// File: tb/test_ret_stack_ctx.sv
module test_ret_stack_ctx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] pcIn = '0;
  logic        callReq = 0, intReq = 0, nmiReq = 0, retReq = 0, retiReq = 0;
  logic        flagWr = 0, carryIn = 0, zeroIn = 0;
  logic [11:0] popPc;
  logic        popEmpty, carryOut, zeroOut;
  logic [1:0]  ctxOut;

  always #10 clk = ~clk;

  ret_stack_ctx i_ret_stack_ctx (
    .clk(clk), .rstN(rstN), .pcIn(pcIn),
    .callReq(callReq), .intReq(intReq), .nmiReq(nmiReq),
    .retReq(retReq), .retiReq(retiReq),
    .flagWr(flagWr), .carryIn(carryIn), .zeroIn(zeroIn),
    .popPc(popPc), .popEmpty(popEmpty), .carryOut(carryOut),
    .zeroOut(zeroOut), .ctxOut(ctxOut)
  );

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { int pc; bit empty; string tag; } exp_t;
  exp_t expQ[$];
  int   mStk[$];
  int   mHist[$];
  int   mCtx = 2;
  int   mC[3] = '{0, 0, 0};
  int   mZ[3] = '{0, 0, 0};

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one request set, updates model, queues expected pops
  task automatic doOp(bit c, bit i, bit n, bit r, bit ri, int pc, string tag);
    @(posedge clk); #1;
    pcIn = pc[11:0];
    callReq = c; intReq = i; nmiReq = n; retReq = r; retiReq = ri;
    if (n || i || c) begin
      mStk.push_front(pc);
      if (mStk.size() > 6) void'(mStk.pop_back());
      if (n || i) begin
        mHist.push_front(mCtx);
        if (mHist.size() > 2) void'(mHist.pop_back());
        mCtx = n ? 2 : 1;
      end
    end else if (r || ri) begin
      exp_t e;
      e.tag = tag;
      if (mStk.size() == 0) begin e.pc = (pc + 1) & 12'hFFF; e.empty = 1; end
      else begin e.pc = mStk.pop_front(); e.empty = 0; end
      expQ.push_back(e);
      if (ri) mCtx = (mHist.size() > 0) ? mHist.pop_front() : 0;
    end
    @(posedge clk); #1;
    callReq = 0; intReq = 0; nmiReq = 0; retReq = 0; retiReq = 0;
  endtask

  task automatic setFlags(bit c, bit z);
    @(posedge clk); #1;
    flagWr = 1; carryIn = c; zeroIn = z;
    mC[mCtx] = c; mZ[mCtx] = z;
    @(posedge clk); #1;
    flagWr = 0;
  endtask

  task automatic chkCtx(string tag);
    @(negedge clk);
    check({tag, " ctx"}, ctxOut, mCtx);
    check({tag, " carry"}, carryOut, mC[mCtx]);
    check({tag, " zero"}, zeroOut, mZ[mCtx]);
  endtask

  // monitor: compares each pop against the scoreboard
  always @(negedge clk) begin
    if (rstN && (retReq || retiReq) && !(callReq || intReq || nmiReq)) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected pop actual=%0h expected=none", popPc);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " popPc"}, popPc, e.pc);
        check({e.tag, " popEmpty"}, popEmpty, e.empty);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chkCtx("R1 reset");
    doOp(0, 0, 0, 1, 0, 12'h123, "R1 R4 empty after reset");
    doOp(0, 0, 0, 1, 0, 12'hFFF, "R4 wrap empty");
    setFlags(1, 0);
    chkCtx("R9 nmi flags");
    doOp(0, 0, 0, 0, 1, 12'h010, "R11 reti no history");
    chkCtx("R11 normal ctx");
    setFlags(0, 1);
    chkCtx("R9 normal flags");
    // R2 LIFO
    doOp(1, 0, 0, 0, 0, 12'h101, "R2 call");
    doOp(1, 0, 0, 0, 0, 12'h202, "R2 call");
    doOp(1, 0, 0, 0, 0, 12'h303, "R2 call");
    for (int k = 0; k < 3; k++) doOp(0, 0, 0, 1, 0, 12'h000, "R2 ret");
    chkCtx("R8 ret keeps ctx");
    // R3 saturation
    for (int k = 0; k < 9; k++) doOp(1, 0, 0, 0, 0, 12'h400 + k, "R3 call");
    for (int k = 0; k < 8; k++) doOp(0, 0, 0, 1, 0, 12'h500 + k, "R3 ret");
    // nested contexts
    doOp(1, 0, 0, 0, 0, 12'hA00, "R7 call");
    doOp(0, 1, 0, 0, 0, 12'hB00, "R5 int");
    chkCtx("R5 int ctx");
    setFlags(1, 1);
    doOp(0, 0, 1, 0, 0, 12'hC00, "R6 nmi");
    chkCtx("R6 nmi ctx R9");
    doOp(0, 0, 0, 1, 0, 12'h000, "R8 ret in nmi");
    chkCtx("R8 ctx kept");
    doOp(0, 0, 0, 0, 1, 12'h000, "R7 reti to int");
    chkCtx("R7 back to int");
    doOp(0, 0, 0, 0, 1, 12'h000, "R7 reti to normal");
    chkCtx("R7 back to normal R9");
    // R10 priority
    doOp(1, 0, 1, 1, 1, 12'hD01, "R10 nmi wins");
    chkCtx("R10 nmi ctx");
    doOp(1, 1, 0, 0, 1, 12'hD02, "R10 int wins");
    chkCtx("R10 int ctx");
    doOp(0, 0, 0, 1, 1, 12'h000, "R10 reti wins");
    chkCtx("R10 reti ctx");
    doOp(0, 0, 0, 1, 1, 12'h000, "R10 reti wins again");
    chkCtx("R10 reti ctx2");
    doOp(0, 0, 0, 1, 0, 12'h000, "R10 ret");
    doOp(0, 0, 0, 1, 0, 12'h0AB, "R4 empty end");
    repeat (2) @(posedge clk);
    check("R2 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule